// File: doc/BRIEF.md
# Hash State Save/Restore Port

This block sits beside a multi-algorithm hash engine and gives software a small 32-bit register window through which the engine's intermediate state can be captured and later restored. Every chaining-value word goes through a single register offset: each accepted access to that offset moves an internal word pointer on by one. The pointer wraps after the last word that the selected algorithm uses. The same offset serves for reading out a finished digest, which is simply the leading words of the chain.

The block owns the chaining-word array and offers the hash datapath a side port that reads any word and overwrites any word. It also holds a 64-bit processed-length counter that is split across two registers, and a mode register carrying the algorithm code, a keyed-hash enable and a 6-bit data-endianness field; these are presented to the datapath as plain outputs. A busy input from the engine shows up in the status register. While busy is high, chain accesses are blocked so that software cannot disturb a running compression.

Top module: `hash_state_port`

## Requirements
- R1: After synchronous reset the mode register, both length registers, the word pointer and every chain word are zero, and `bus_rvalid` is low.
- R2: The mode register at offset 0x00 keeps bits 31:26 (endianness), bit 22 (keyed-hash enable) and bits 18:16 (algorithm code). It reads back all other bits as zero and drives the three fields on `cfg_endian`, `cfg_hmac` and `cfg_algo`.
- R3: Successive accepted writes to the chain offset 0x04 store words at indices 0, 1, 2, … in order, and each stored word is visible on the datapath read port at its index.
- R4: A read (`bus_rd` high, `bus_wr` low) returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle later. Successive chain reads return the words in index order.
- R5: Algorithm codes 0 (SHA-256), 1 (SHA-224) and 4 (SM3) use 8 chain words; codes 2 (SHA-384) and 3 (SHA-512) use 16. After the last word the pointer wraps to index 0.
- R6: Any write to the mode register returns the word pointer to index 0.
- R7: While `eng_busy` is high, chain writes are ignored, chain reads return zero, and the pointer does not move.
- R8: Algorithm codes 5, 6 and 7 give a word count of zero: chain writes change nothing, chain reads return zero, and the pointer stays put.
- R9: Offsets 0x60 and 0x64 read and write the low and high halves of the 64-bit length, which is driven on `msg_len`. A `dp_len_wr` pulse loads `dp_len_data` and wins over a bus write in the same cycle.
- R10: The status register at 0x58 reads `eng_busy` in bit 0, the chain word count in bits 12:8 and the digest word count in bits 20:16 (7 for SHA-224, 8 for SHA-256 and SM3, 12 for SHA-384, 16 for SHA-512, 0 for unsupported codes).
- R11: A datapath write (`dp_wr_en`) updates the addressed chain word whether or not busy is set, and a later bus chain read returns the new value.
- R12: A read of any unmapped offset returns zero. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is high) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after an accepted read |
| eng_busy | input | 1 | Hash engine is processing |
| dp_wr_en | input | 1 | Datapath chain word write enable |
| dp_wr_idx | input | IDX_W | Datapath write word index |
| dp_wr_data | input | 32 | Datapath write word |
| dp_rd_idx | input | IDX_W | Datapath read word index |
| dp_rd_data | output | 32 | Chain word at dp_rd_idx |
| dp_len_wr | input | 1 | Datapath length load |
| dp_len_data | input | 64 | Length value to load |
| cfg_algo | output | 3 | Algorithm code |
| cfg_hmac | output | 1 | Keyed-hash enable |
| cfg_endian | output | 6 | Data endianness field |
| cfg_word_count | output | CNT_W | Chain words used by current algorithm |
| msg_len | output | 64 | Processed message length |

## Verification
The hardest situation to reach is a pointer that has already advanced partway through a long chain when something cuts across it: a busy window, a change to an unsupported algorithm code, or a mode rewrite. Any of these must hold the pointer exactly where it is, or return it to zero. The stimulus keeps a bench-side model of pointer and array and mixes random chain traffic with random busy levels and random algorithm codes, unsupported ones included. Every chain read therefore lands on an arbitrary pointer position that the model predicts. Directed sequences add the full 16-word wrap and readback after a busy or unsupported interval.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;

    localparam int DATA_W    = 32;
    localparam int MAX_WORDS = 16;
    localparam int IDX_W     = $clog2(MAX_WORDS);
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int ALGO_W    = 3;
    localparam int ENDIAN_W  = 6;

    // Register byte offsets
    localparam int OFF_MODE   = 'h00;
    localparam int OFF_CHAIN  = 'h04;
    localparam int OFF_STATUS = 'h58;
    localparam int OFF_LENLO  = 'h60;
    localparam int OFF_LENHI  = 'h64;

    // Field positions inside the mode register
    localparam int POS_ALGO   = 16;
    localparam int POS_HMAC   = 22;
    localparam int POS_ENDIAN = 26;

    // Field positions inside the status register
    localparam int POS_CNT    = 8;
    localparam int POS_DIG    = 16;

    typedef enum logic [ALGO_W-1:0] {
        ALG_SHA256 = 3'd0,
        ALG_SHA224 = 3'd1,
        ALG_SHA384 = 3'd2,
        ALG_SHA512 = 3'd3,
        ALG_SM3    = 3'd4
    } algo_e;

    typedef struct packed {
        logic [ENDIAN_W-1:0] endian;
        logic                hmac;
        logic [ALGO_W-1:0]   algo;
    } mode_t;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_MODE,
        RS_CHAIN,
        RS_STATUS,
        RS_LENLO,
        RS_LENHI
    } rsel_e;

    typedef struct packed {
        logic  mode_wr;
        logic  chain_wr;
        logic  chain_rd;
        logic  lenlo_wr;
        logic  lenhi_wr;
        logic  rd_fire;
        rsel_e rsel;
    } strobe_t;

    function automatic logic [CNT_W-1:0] chain_words(input logic [ALGO_W-1:0] a);
        case (a)
            ALG_SHA256, ALG_SHA224, ALG_SM3: chain_words = CNT_W'(8);
            ALG_SHA384, ALG_SHA512:          chain_words = CNT_W'(16);
            default:                         chain_words = '0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] digest_words(input logic [ALGO_W-1:0] a);
        case (a)
            ALG_SHA224:          digest_words = CNT_W'(7);
            ALG_SHA256, ALG_SM3: digest_words = CNT_W'(8);
            ALG_SHA384:          digest_words = CNT_W'(12);
            ALG_SHA512:          digest_words = CNT_W'(16);
            default:             digest_words = '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[POS_ENDIAN +: ENDIAN_W] = m.endian;
        w[POS_HMAC]               = m.hmac;
        w[POS_ALGO +: ALGO_W]     = m.algo;
        return w;
    endfunction

    function automatic mode_t word_to_mode(input logic [DATA_W-1:0] w);
        mode_t m;
        m.endian = w[POS_ENDIAN +: ENDIAN_W];
        m.hmac   = w[POS_HMAC];
        m.algo   = w[POS_ALGO +: ALGO_W];
        return m;
    endfunction

endpackage

// File: rtl/hsp_decode.sv
`timescale 1ns/1ps
module hsp_decode
    import hsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              busy,
    input  logic [CNT_W-1:0]  count,
    output strobe_t           stb
);

    logic chain_open;
    logic hit_mode, hit_chain, hit_status, hit_lenlo, hit_lenhi;

    assign chain_open = !busy && (count != '0);
    assign hit_mode   = (bus_addr == ADDR_W'(OFF_MODE));
    assign hit_chain  = (bus_addr == ADDR_W'(OFF_CHAIN));
    assign hit_status = (bus_addr == ADDR_W'(OFF_STATUS));
    assign hit_lenlo  = (bus_addr == ADDR_W'(OFF_LENLO));
    assign hit_lenhi  = (bus_addr == ADDR_W'(OFF_LENHI));

    always_comb begin
        stb          = '0;
        stb.rsel     = RS_NONE;
        stb.rd_fire  = bus_rd && !bus_wr;
        if (bus_wr) begin
            stb.mode_wr  = hit_mode;
            stb.chain_wr = hit_chain && chain_open;
            stb.lenlo_wr = hit_lenlo;
            stb.lenhi_wr = hit_lenhi;
        end
        if (stb.rd_fire) begin
            if (hit_mode)
                stb.rsel = RS_MODE;
            else if (hit_chain && chain_open) begin
                stb.rsel     = RS_CHAIN;
                stb.chain_rd = 1'b1;
            end
            else if (hit_status)
                stb.rsel = RS_STATUS;
            else if (hit_lenlo)
                stb.rsel = RS_LENLO;
            else if (hit_lenhi)
                stb.rsel = RS_LENHI;
        end
    end

endmodule

// File: rtl/hsp_word_ptr.sv
`timescale 1ns/1ps
module hsp_word_ptr
    import hsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] count,
    output logic [IDX_W-1:0] ptr
);

    logic [CNT_W-1:0] next_wide;
    logic             at_last;

    assign next_wide = CNT_W'(ptr) + CNT_W'(1);
    assign at_last   = (next_wide >= count);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (clear)
            ptr <= '0;
        else if (step && (count != '0))
            ptr <= at_last ? '0 : IDX_W'(next_wide);
    end

endmodule

// File: rtl/hsp_chain_store.sv
`timescale 1ns/1ps
module hsp_chain_store
    import hsp_pkg::*;
#(
    parameter int WORDS = MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rword,
    input  logic              dp_we,
    input  logic [IDX_W-1:0]  dp_widx,
    input  logic [DATA_W-1:0] dp_wdata,
    input  logic [IDX_W-1:0]  dp_ridx,
    output logic [DATA_W-1:0] dp_rword
);

    logic [DATA_W-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic dp_hit, bus_hit;
        assign dp_hit  = dp_we  && (dp_widx == IDX_W'(i));
        assign bus_hit = bus_we && (bus_idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= '0;
            else if (dp_hit)
                words[i] <= dp_wdata;
            else if (bus_hit)
                words[i] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rword = '0;
        dp_rword  = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (bus_idx == IDX_W'(k)) bus_rword = words[k];
            if (dp_ridx == IDX_W'(k)) dp_rword  = words[k];
        end
    end

endmodule

// File: rtl/hsp_cfg_regs.sv
`timescale 1ns/1ps
module hsp_cfg_regs
    import hsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_wr,
    input  logic                lenlo_wr,
    input  logic                lenhi_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                dp_len_wr,
    input  logic [2*DATA_W-1:0] dp_len_data,
    output mode_t               mode,
    output logic [2*DATA_W-1:0] len
);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= '0;
        else if (mode_wr)
            mode <= word_to_mode(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)
            len <= '0;
        else if (dp_len_wr)
            len <= dp_len_data;
        else begin
            if (lenlo_wr) len[DATA_W-1:0]        <= wdata;
            if (lenhi_wr) len[2*DATA_W-1:DATA_W] <= wdata;
        end
    end

endmodule

// File: rtl/hash_state_port.sv
`timescale 1ns/1ps
module hash_state_port
    import hsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic                eng_busy,
    input  logic                dp_wr_en,
    input  logic [IDX_W-1:0]    dp_wr_idx,
    input  logic [DATA_W-1:0]   dp_wr_data,
    input  logic [IDX_W-1:0]    dp_rd_idx,
    output logic [DATA_W-1:0]   dp_rd_data,
    input  logic                dp_len_wr,
    input  logic [2*DATA_W-1:0] dp_len_data,
    output logic [ALGO_W-1:0]   cfg_algo,
    output logic                cfg_hmac,
    output logic [ENDIAN_W-1:0] cfg_endian,
    output logic [CNT_W-1:0]    cfg_word_count,
    output logic [2*DATA_W-1:0] msg_len
);

    strobe_t           stb;
    mode_t             mode;
    logic [IDX_W-1:0]  cur_ptr;
    logic [DATA_W-1:0] chain_word;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_mux;

    assign cfg_algo       = mode.algo;
    assign cfg_hmac       = mode.hmac;
    assign cfg_endian     = mode.endian;
    assign cfg_word_count = chain_words(mode.algo);

    hsp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .busy     (eng_busy),
        .count    (cfg_word_count),
        .stb      (stb)
    );

    hsp_word_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clear (stb.mode_wr),
        .step  (stb.chain_wr || stb.chain_rd),
        .count (cfg_word_count),
        .ptr   (cur_ptr)
    );

    hsp_chain_store #(.WORDS(MAX_WORDS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (stb.chain_wr),
        .bus_idx   (cur_ptr),
        .bus_wdata (bus_wdata),
        .bus_rword (chain_word),
        .dp_we     (dp_wr_en),
        .dp_widx   (dp_wr_idx),
        .dp_wdata  (dp_wr_data),
        .dp_ridx   (dp_rd_idx),
        .dp_rword  (dp_rd_data)
    );

    hsp_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (stb.mode_wr),
        .lenlo_wr    (stb.lenlo_wr),
        .lenhi_wr    (stb.lenhi_wr),
        .wdata       (bus_wdata),
        .dp_len_wr   (dp_len_wr),
        .dp_len_data (dp_len_data),
        .mode        (mode),
        .len         (msg_len)
    );

    always_comb begin
        status_word                      = '0;
        status_word[0]                   = eng_busy;
        status_word[POS_CNT +: CNT_W]    = cfg_word_count;
        status_word[POS_DIG +: CNT_W]    = digest_words(mode.algo);
    end

    always_comb begin
        case (stb.rsel)
            RS_MODE:   rd_mux = mode_to_word(mode);
            RS_CHAIN:  rd_mux = chain_word;
            RS_STATUS: rd_mux = status_word;
            RS_LENLO:  rd_mux = msg_len[DATA_W-1:0];
            RS_LENHI:  rd_mux = msg_len[2*DATA_W-1:DATA_W];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= stb.rd_fire;
            if (stb.rd_fire)
                bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/hash_state_port_chk.sv
`timescale 1ns/1ps
module hash_state_port_chk
    import hsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              eng_busy,
    input logic [ALGO_W-1:0] cfg_algo,
    input logic [CNT_W-1:0]  cfg_word_count,
    input logic [IDX_W-1:0]  cur_ptr
);

    logic chain_acc;
    assign chain_acc = (bus_wr || bus_rd) && (bus_addr == ADDR_W'(OFF_CHAIN));

    assert_ptr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_word_count == '0) || (CNT_W'(cur_ptr) < cfg_word_count));

    assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFF_CHAIN) && !eng_busy
         && cfg_word_count != '0 && (CNT_W'(cur_ptr) + CNT_W'(1) < cfg_word_count))
        |=> (CNT_W'(cur_ptr) == CNT_W'($past(cur_ptr)) + CNT_W'(1)));

    assert_step_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || (bus_rd && !bus_wr)) && bus_addr == ADDR_W'(OFF_CHAIN) && !eng_busy
         && cfg_word_count != '0 && (CNT_W'(cur_ptr) + CNT_W'(1) == cfg_word_count))
        |=> (cur_ptr == '0));

    assert_mode_clears_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFF_MODE)) |=> (cur_ptr == '0));

    assert_busy_holds_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (chain_acc && eng_busy) |=> $stable(cur_ptr));

    assert_busy_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFF_CHAIN) && eng_busy)
        |=> (bus_rdata == '0));

    assert_unsup_count_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_algo > 3'd4) |-> (cfg_word_count == '0));

    assert_rvalid_timing_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr) |=> bus_rvalid);

    assert_no_spurious_rvalid_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && !bus_wr) |=> !bus_rvalid);

    assert_status_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFF_STATUS))
        |=> (bus_rdata[0] == $past(eng_busy)));

endmodule

bind hash_state_port hash_state_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .bus_rvalid     (bus_rvalid),
    .eng_busy       (eng_busy),
    .cfg_algo       (cfg_algo),
    .cfg_word_count (cfg_word_count),
    .cur_ptr        (cur_ptr)
);

// File: tb/hash_state_port_test.sv
`timescale 1ns/1ps
module hash_state_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        eng_busy = 1'b0;
    logic        dp_wr_en = 1'b0;
    logic [3:0]  dp_wr_idx = '0;
    logic [31:0] dp_wr_data = '0;
    logic [3:0]  dp_rd_idx = '0;
    logic [31:0] dp_rd_data;
    logic        dp_len_wr = 1'b0;
    logic [63:0] dp_len_data = '0;
    logic [2:0]  cfg_algo;
    logic        cfg_hmac;
    logic [5:0]  cfg_endian;
    logic [4:0]  cfg_word_count;
    logic [63:0] msg_len;

    always #4 clk = ~clk;

    hash_state_port #(.ADDR_W(8)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .eng_busy(eng_busy), .dp_wr_en(dp_wr_en),
        .dp_wr_idx(dp_wr_idx), .dp_wr_data(dp_wr_data), .dp_rd_idx(dp_rd_idx),
        .dp_rd_data(dp_rd_data), .dp_len_wr(dp_len_wr), .dp_len_data(dp_len_data),
        .cfg_algo(cfg_algo), .cfg_hmac(cfg_hmac), .cfg_endian(cfg_endian),
        .cfg_word_count(cfg_word_count), .msg_len(msg_len)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model
    logic [31:0] m_chain [16];
    int          m_ptr;
    logic [31:0] m_mode;
    logic [63:0] m_len;

    localparam logic [31:0] MODE_MASK = 32'hFC47_0000;

    function automatic int exp_cnt(input logic [2:0] a);
        if (a == 3'd0 || a == 3'd1 || a == 3'd4) return 8;
        if (a == 3'd2 || a == 3'd3) return 16;
        return 0;
    endfunction

    function automatic int exp_dig(input logic [2:0] a);
        case (a)
            3'd0: return 8;
            3'd1: return 7;
            3'd2: return 12;
            3'd3: return 16;
            3'd4: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_status(input logic [2:0] a, input logic b);
        return {11'd0, 5'(exp_dig(a)), 3'd0, 5'(exp_cnt(a)), 7'd0, b};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    // Model-tracked operations
    task automatic m_write_mode(input logic [31:0] d);
        bus_write(8'h00, d);
        m_mode = d & MODE_MASK;
        m_ptr = 0;
    endtask

    task automatic m_chain_write(input logic [31:0] d);
        int n;
        bus_write(8'h04, d);
        n = exp_cnt(m_mode[18:16]);
        if (!eng_busy && n != 0) begin
            m_chain[m_ptr] = d;
            m_ptr = (m_ptr + 1 == n) ? 0 : m_ptr + 1;
        end
    endtask

    task automatic m_chain_read(input string tag);
        logic [31:0] d; logic v; logic [31:0] e; int n;
        n = exp_cnt(m_mode[18:16]);
        e = (!eng_busy && n != 0) ? m_chain[m_ptr] : 32'd0;
        bus_read(8'h04, d, v);
        check(tag, {32'd0, d}, {32'd0, e});
        if (!eng_busy && n != 0) m_ptr = (m_ptr + 1 == n) ? 0 : m_ptr + 1;
    endtask

    initial begin : wdog
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic v;
        void'($urandom(32'd20240722));
        for (int i = 0; i < 16; i++) m_chain[i] = '0;
        m_ptr = 0; m_mode = '0; m_len = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rvalid low", {63'd0, bus_rvalid}, 64'd0);
        bus_read(8'h00, d, v); check("R1 mode zero", {32'd0, d}, 64'd0);
        check("R4 rvalid after read", {63'd0, v}, 64'd1);
        bus_read(8'h60, d, v); check("R1 len lo zero", {32'd0, d}, 64'd0);
        bus_read(8'h64, d, v); check("R1 len hi zero", {32'd0, d}, 64'd0);
        m_chain_read("R1 chain word0 zero");
        check("R1 msg_len zero", msg_len, 64'd0);

        // R2: mode fields
        m_write_mode(32'hFFFF_FFFF & ~32'h0007_0000 | 32'h0003_0000);
        bus_read(8'h00, d, v); check("R2 mode readback", {32'd0, d}, {32'd0, m_mode});
        check("R2 cfg_endian", {58'd0, cfg_endian}, 64'h3F);
        check("R2 cfg_hmac", {63'd0, cfg_hmac}, 64'd1);
        check("R2 cfg_algo", {61'd0, cfg_algo}, 64'd3);
        m_write_mode({6'h2A, 3'd0, 1'b1, 3'd0, 3'd3, 16'h0});
        check("R2 cfg_endian 2A", {58'd0, cfg_endian}, 64'h2A);

        // R3/R5: 16-word chain, wrap
        for (int i = 0; i < 16; i++) m_chain_write(32'hA000_0000 + 32'(i * 17));
        for (int i = 0; i < 16; i++) begin
            dp_rd_idx = 4'(i); #1;
            check("R3 dp read order", {32'd0, dp_rd_data}, {32'd0, 32'hA000_0000 + 32'(i * 17)});
        end
        for (int i = 0; i < 16; i++) m_chain_read("R4 chain read order");
        m_chain_read("R5 wrap to word0 (16)");

        // R5: 8-word wrap
        m_write_mode({6'h2A, 10'd0, 16'h0}); // SHA-256
        for (int i = 0; i < 8; i++) m_chain_read("R5 8-word read");
        m_chain_read("R5 wrap to word0 (8)");

        // R6: mode write resets pointer
        m_chain_write(32'h1111_0001);
        m_chain_write(32'h1111_0002);
        m_write_mode({6'h2A, 10'd0, 16'h0});
        m_chain_read("R6 pointer back to 0");

        // R7: busy blocks chain
        eng_busy = 1'b1;
        m_chain_write(32'hDEAD_BEEF);
        m_chain_read("R7 busy read zero");
        bus_read(8'h58, d, v); check("R10 status busy", {32'd0, d}, {32'd0, exp_status(3'd0, 1'b1)});
        eng_busy = 1'b0;
        m_chain_read("R7 pointer unmoved after busy");

        // R8: unsupported code
        m_write_mode({6'h2A, 10'd6, 16'h0} | 32'h0006_0000);
        check("R8 count zero", {59'd0, cfg_word_count}, 64'd0);
        m_chain_write(32'hBAD0_BAD0);
        m_chain_read("R8 unsupported read zero");
        m_write_mode({16'd0, 16'h0});
        for (int i = 0; i < 8; i++) m_chain_read("R8 array untouched");

        // R10: status per algo
        for (int a = 0; a < 8; a++) begin
            m_write_mode(32'(a) << 16);
            bus_read(8'h58, d, v);
            check("R10 status counts", {32'd0, d}, {32'd0, exp_status(3'(a), 1'b0)});
        end

        // R9: length registers
        bus_write(8'h60, 32'h1234_5678); bus_write(8'h64, 32'h9ABC_DEF0);
        m_len = 64'h9ABC_DEF0_1234_5678;
        bus_read(8'h60, d, v); check("R9 len lo", {32'd0, d}, {32'd0, 32'h1234_5678});
        bus_read(8'h64, d, v); check("R9 len hi", {32'd0, d}, {32'd0, 32'h9ABC_DEF0});
        check("R9 msg_len port", msg_len, m_len);
        @(negedge clk);
        dp_len_wr = 1'b1; dp_len_data = 64'h0000_0001_0000_0040;
        bus_wr = 1'b1; bus_addr = 8'h60; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        dp_len_wr = 1'b0; bus_wr = 1'b0;
        m_len = 64'h0000_0001_0000_0040;
        check("R9 datapath load wins", msg_len, m_len);

        // R11: datapath write
        m_write_mode(32'h0004_0000); // SM3
        @(negedge clk);
        eng_busy = 1'b1; dp_wr_en = 1'b1; dp_wr_idx = 4'd0; dp_wr_data = 32'h5A5A_0000;
        @(negedge clk);
        dp_wr_en = 1'b0; eng_busy = 1'b0;
        m_chain[0] = 32'h5A5A_0000;
        m_chain_read("R11 datapath word visible");

        // R12: unmapped
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, d, v); check("R12 unmapped read zero", {32'd0, d}, 64'd0);
        bus_read(8'h00, d, v); check("R12 mode untouched", {32'd0, d}, {32'd0, m_mode});
        check("R12 len untouched", msg_len, m_len);

        // Random phase
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            eng_busy = ($urandom_range(0, 4) == 0);
            case (op)
                0: m_write_mode($urandom());
                1, 2, 3: m_chain_write($urandom());
                4, 5, 6: m_chain_read("R4 random chain read");
                7: begin
                    bus_read(8'h58, d, v);
                    check("R10 random status", {32'd0, d}, {32'd0, exp_status(m_mode[18:16], eng_busy)});
                end
                8: begin
                    logic [31:0] r; r = $urandom();
                    bus_write(8'h64, r); m_len[63:32] = r;
                    bus_read(8'h64, d, v); check("R9 random len hi", {32'd0, d}, {32'd0, r});
                end
                default: begin
                    bus_read(8'h00, d, v);
                    check("R2 random mode", {32'd0, d}, {32'd0, m_mode});
                end
            endcase
        end
        eng_busy = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule